// File: doc/BRIEF.md
# Transmit Descriptor Gather Sequencer

This block turns one transmit frame descriptor into a sequence of buffer read requests. A controller pulses `start` with a ring base and a ring index. The block computes the descriptor's location in memory and presents it on `desc_addr`. It then accepts the 128-byte descriptor as 32 dwords on a valid/ready stream and stores it locally.

After the last dword is in, the block checks the active-buffer count. It then walks the packed 6-byte buffer entries in order. For each entry it issues one read request with a 36-bit address and a 12-bit length. Entries are packed, so every odd entry starts mid-dword and is rebuilt from two stored dwords.

The block checks each length and the running frame size as the requests are accepted. A pulse on `done` closes the frame, and three error flags report any fault until the next start.

Top module: `tdg_gather`

## Requirements
- R1: When `start` is accepted, `desc_addr` becomes `ring_base*256 + ring_idx*128`, truncated to 36 bits, and holds while `busy` is high.
- R2: `dw_ready` is high only while the descriptor is being loaded, and exactly 32 dwords are accepted. Dword k carries descriptor bytes 4k..4k+3, with byte 4k in bits 7:0.
- R3: The active-buffer count is taken from bits 4:0 of descriptor byte 3 (dword 0 bits 28:24). Bytes 0 to 2 and bits 7:5 of byte 3 have no effect.
- R4: A count of 0 or above 20 sets `err_count`, issues no request, and still ends with `done`.
- R5: Entry i starts at descriptor byte 4+6i. It holds a 32-bit little-endian low address followed by a 16-bit word whose bits 3:0 give address bits 35:32 and whose bits 15:4 give the length. Odd entries straddle a dword boundary.
- R6: Requests go out in entry order 0 to count-1. While `req_valid` is high and `req_ready` is low, the request stays up with address and length unchanged.
- R7: A length of 0 or above 4092 sets `err_len`. That entry's request is still issued, and no later entry is requested.
- R8: If the running sum of accepted lengths exceeds 8192, `err_size` is set and the frame stops after that request. A sum of exactly 8192 is legal.
- R9: `done` is high for exactly one cycle, in the cycle after the final request is accepted. The error flags are valid from that cycle and stay until the next accepted `start`, which clears them.
- R10: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one descriptor (taken only when idle) |
| ring_base | input | 28 | Ring base, address bits 35:8 |
| ring_idx | input | 8 | Descriptor index in the ring |
| busy | output | 1 | Sequencer is working on a descriptor |
| desc_addr | output | 36 | Byte address of the descriptor |
| dw_valid | input | 1 | Descriptor dword valid |
| dw_ready | output | 1 | Descriptor dword accepted |
| dw_data | input | 32 | Descriptor dword |
| req_valid | output | 1 | Buffer read request valid |
| req_ready | input | 1 | Buffer read request accepted |
| req_addr | output | 36 | Buffer address |
| req_len | output | 12 | Buffer length in bytes |
| done | output | 1 | One-cycle end-of-frame pulse |
| err_count | output | 1 | Bad active-buffer count |
| err_len | output | 1 | Bad buffer length |
| err_size | output | 1 | Frame size exceeded |

## Verification
The bench targets the misaligned odd entries. A design that picks the wrong halfwords sends scrambled addresses or lengths on every second request. It also covers the count limits 0, 20 and 21, with junk in the reserved count bits. A block that reads too many bits or uses an off-by-one limit would issue requests or miss the error.

Length and size tests sit on both sides of their limits: 4092 against 4093, zero length, and a total of exactly 8192 against an overflow. A block that stops before the offending request, or keeps going after it, shows a wrong request count. A stalled ready line and a second start during loading expose requests that move while waiting, and a descriptor address that is recaptured.

// File: rtl/tdg_pkg.sv
package tdg_pkg;
  localparam int ADDR_W  = 36;
  localparam int LEN_W   = 12;
  localparam int WORD_W  = 32;
  localparam int CNT_W   = 5;
  localparam int CNT_LSB = 24;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CHECK,
    ST_REQ,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
  } buf_ent_t;
endpackage

// File: rtl/tdg_desc_store.sv
module tdg_desc_store
  import tdg_pkg::*;
#(
  parameter int DWORDS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              full,
  output logic [WORD_W-1:0] words [DWORDS]
);
  localparam int IW = $clog2(DWORDS);
  localparam int CW = IW + 1;

  logic [CW-1:0]     cnt_q, cnt_d;
  logic [WORD_W-1:0] mem_q [DWORDS];

  always_comb begin
    cnt_d = cnt_q;
    if (clr)        cnt_d = '0;
    else if (wr_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Data storage carries no reset; it is always fully written before use.
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[cnt_q[IW-1:0]] <= wr_data;
  end

  assign full  = (cnt_q == CW'(DWORDS));
  assign words = mem_q;
endmodule

// File: rtl/tdg_entry_unpack.sv
module tdg_entry_unpack
  import tdg_pkg::*;
#(
  parameter int ENTRIES = 20,
  parameter int DWORDS  = 32,
  parameter int SEL_W   = 5
) (
  input  logic [WORD_W-1:0] words [DWORDS],
  input  logic [SEL_W-1:0]  sel,
  output logic [CNT_W-1:0]  count,
  output buf_ent_t          ent
);
  buf_ent_t ent_all [ENTRIES];

  assign count = words[0][CNT_LSB +: CNT_W];

  // Entry g begins at byte 4+6g: even entries are dword aligned,
  // odd entries begin in the upper halfword of a dword.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    localparam int BOFF = 4 + 6 * g;
    localparam int WI   = BOFF / 4;
    logic [31:0] lo;
    logic [15:0] hi;
    if ((BOFF % 4) == 0) begin : g_al
      assign lo = words[WI];
      assign hi = words[WI+1][15:0];
    end else begin : g_mis
      assign lo = {words[WI+1][15:0], words[WI][31:16]};
      assign hi = words[WI+1][31:16];
    end
    assign ent_all[g].addr = {hi[3:0], lo};
    assign ent_all[g].len  = hi[15:4];
  end

  assign ent = ent_all[sel];
endmodule

// File: rtl/tdg_seq_ctrl.sv
module tdg_seq_ctrl
  import tdg_pkg::*;
#(
  parameter int ENTRIES   = 20,
  parameter int LEN_MAX   = 4092,
  parameter int FRAME_MAX = 8192,
  parameter int SEL_W     = 5,
  parameter int TOT_W     = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             full,
  input  logic [CNT_W-1:0] count,
  input  logic [LEN_W-1:0] ent_len,
  input  logic             req_ready,
  output logic             busy,
  output logic             take,
  output logic             load_en,
  output logic [SEL_W-1:0] sel,
  output logic             req_valid,
  output logic             done,
  output logic             err_count,
  output logic             err_len,
  output logic             err_size
);
  seq_state_e       st_q, st_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [TOT_W-1:0] tot_q, tot_d, tot_sum;
  logic             ec_q, ec_d, el_q, el_d, es_q, es_d;
  logic             cnt_bad, len_bad, size_bad, last, fire;

  assign cnt_bad  = (count == '0) || (int'(count) > ENTRIES);
  assign len_bad  = (ent_len == '0) || (ent_len > LEN_W'(LEN_MAX));
  assign tot_sum  = tot_q + TOT_W'(ent_len);
  assign size_bad = (tot_sum > TOT_W'(FRAME_MAX));
  assign last     = ((int'(sel_q) + 1) == int'(count));
  assign fire     = (st_q == ST_REQ) && req_ready;
  assign take     = (st_q == ST_IDLE) && start;

  always_comb begin
    st_d  = st_q;
    sel_d = sel_q;
    tot_d = tot_q;
    ec_d  = ec_q;
    el_d  = el_q;
    es_d  = es_q;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d = ST_LOAD;
        ec_d = 1'b0;
        el_d = 1'b0;
        es_d = 1'b0;
      end
      ST_LOAD: if (full) st_d = ST_CHECK;
      ST_CHECK: begin
        sel_d = '0;
        tot_d = '0;
        if (cnt_bad) begin
          ec_d = 1'b1;
          st_d = ST_DONE;
        end else begin
          st_d = ST_REQ;
        end
      end
      ST_REQ: if (fire) begin
        tot_d = tot_sum;
        el_d  = len_bad;
        es_d  = size_bad;
        if (len_bad || size_bad || last) st_d = ST_DONE;
        else sel_d = sel_q + 1'b1;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      sel_q <= '0;
      tot_q <= '0;
      ec_q  <= 1'b0;
      el_q  <= 1'b0;
      es_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      sel_q <= sel_d;
      tot_q <= tot_d;
      ec_q  <= ec_d;
      el_q  <= el_d;
      es_q  <= es_d;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign load_en   = (st_q == ST_LOAD) && !full;
  assign sel       = sel_q;
  assign req_valid = (st_q == ST_REQ);
  assign done      = (st_q == ST_DONE);
  assign err_count = ec_q;
  assign err_len   = el_q;
  assign err_size  = es_q;
endmodule

// File: rtl/tdg_gather.sv
module tdg_gather
  import tdg_pkg::*;
#(
  parameter int ENTRIES   = 20,
  parameter int DWORDS    = 32,
  parameter int BASE_W    = 28,
  parameter int IDX_W     = 8,
  parameter int LEN_MAX   = 4092,
  parameter int FRAME_MAX = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BASE_W-1:0] ring_base,
  input  logic [IDX_W-1:0]  ring_idx,
  output logic              busy,
  output logic [35:0]       desc_addr,
  input  logic              dw_valid,
  output logic              dw_ready,
  input  logic [31:0]       dw_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [35:0]       req_addr,
  output logic [11:0]       req_len,
  output logic              done,
  output logic              err_count,
  output logic              err_len,
  output logic              err_size
);
  localparam int SEL_W      = $clog2(ENTRIES);
  localparam int TOT_W      = $clog2(ENTRIES * (2 ** LEN_W)) + 1;
  localparam int BASE_SHIFT = ADDR_W - BASE_W;
  localparam int DESC_SHIFT = $clog2(DWORDS * 4);

  logic              take, load_en, full;
  logic [SEL_W-1:0]  sel;
  logic [CNT_W-1:0]  count;
  buf_ent_t          ent;
  logic [WORD_W-1:0] words [DWORDS];
  logic [ADDR_W-1:0] daddr_q, daddr_d;

  always_comb begin
    daddr_d = daddr_q;
    if (take) daddr_d = {ring_base, BASE_SHIFT'(0)} + (ADDR_W'(ring_idx) << DESC_SHIFT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) daddr_q <= '0;
    else        daddr_q <= daddr_d;
  end

  tdg_desc_store #(.DWORDS(DWORDS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (take),
    .wr_en   (dw_valid && load_en),
    .wr_data (dw_data),
    .full    (full),
    .words   (words)
  );

  tdg_entry_unpack #(.ENTRIES(ENTRIES), .DWORDS(DWORDS), .SEL_W(SEL_W)) u_unpack (
    .words (words),
    .sel   (sel),
    .count (count),
    .ent   (ent)
  );

  tdg_seq_ctrl #(
    .ENTRIES(ENTRIES), .LEN_MAX(LEN_MAX), .FRAME_MAX(FRAME_MAX),
    .SEL_W(SEL_W), .TOT_W(TOT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .full      (full),
    .count     (count),
    .ent_len   (ent.len),
    .req_ready (req_ready),
    .busy      (busy),
    .take      (take),
    .load_en   (load_en),
    .sel       (sel),
    .req_valid (req_valid),
    .done      (done),
    .err_count (err_count),
    .err_len   (err_len),
    .err_size  (err_size)
  );

  assign desc_addr = daddr_q;
  assign dw_ready  = load_en;
  assign req_addr  = ent.addr;
  assign req_len   = ent.len;
endmodule

// File: rtl/tdg_gather_chk.sv
module tdg_gather_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic [35:0] desc_addr,
  input logic        dw_ready,
  input logic        req_valid,
  input logic        req_ready,
  input logic [35:0] req_addr,
  input logic [11:0] req_len,
  input logic        done,
  input logic        err_count,
  input logic        err_len,
  input logic        err_size
);
  a_r1_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(desc_addr)));

  a_r2_load_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    dw_ready |-> (busy && !req_valid && !done));

  a_r4_no_req_on_count: assert property (@(posedge clk) disable iff (!rst_n)
    err_count |-> !req_valid);

  a_r6_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_len)));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && !req_valid));

  a_r9_flags_stay: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(err_count) && $stable(err_len) && $stable(err_size)));

  a_r10_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> busy);
endmodule

bind tdg_gather tdg_gather_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .desc_addr (desc_addr),
  .dw_ready  (dw_ready),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_len   (req_len),
  .done      (done),
  .err_count (err_count),
  .err_len   (err_len),
  .err_size  (err_size)
);

// File: tb/tdg_gather_tb.sv
module tdg_gather_tb;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [27:0] ring_base;
  logic [7:0]  ring_idx;
  logic        busy;
  logic [35:0] desc_addr;
  logic        dw_valid;
  logic        dw_ready;
  logic [31:0] dw_data;
  logic        req_valid;
  logic        req_ready;
  logic [35:0] req_addr;
  logic [11:0] req_len;
  logic        done;
  logic        err_count, err_len, err_size;

  int total = 0;
  int bad   = 0;

  typedef struct packed {
    logic [27:0] base;
    logic [7:0]  idx;
    logic [4:0]  cnt;
    logic [11:0] len_base;
    logic [11:0] step;
    logic [4:0]  bad_pos;
    logic [11:0] bad_len;
    logic        stall;
    logic [4:0]  nreq;
    logic [2:0]  errs;   // {size, len, count}
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{28'h0123456, 8'd0,   5'd1,  12'd64,   12'd0, 5'd31, 12'd0,    1'b0, 5'd1,  3'b000},
    '{28'hABCDEF1, 8'd255, 5'd20, 12'd100,  12'd1, 5'd31, 12'd0,    1'b1, 5'd20, 3'b000},
    '{28'h0000001, 8'd3,   5'd0,  12'd10,   12'd1, 5'd31, 12'd0,    1'b0, 5'd0,  3'b001},
    '{28'h0FFFFFF, 8'd7,   5'd21, 12'd10,   12'd1, 5'd31, 12'd0,    1'b0, 5'd0,  3'b001},
    '{28'h1234567, 8'd100, 5'd5,  12'd200,  12'd3, 5'd2,  12'd0,    1'b1, 5'd3,  3'b010},
    '{28'h7654321, 8'd17,  5'd4,  12'd50,   12'd1, 5'd1,  12'd4093, 1'b0, 5'd2,  3'b010},
    '{28'h0F0F0F0, 8'd200, 5'd3,  12'd4092, 12'd0, 5'd2,  12'd8,    1'b1, 5'd3,  3'b000},
    '{28'h0000100, 8'd128, 5'd10, 12'd1000, 12'd1, 5'd31, 12'd0,    1'b1, 5'd9,  3'b100},
    '{28'hFFFFFFF, 8'd255, 5'd2,  12'd4092, 12'd0, 5'd31, 12'd0,    1'b0, 5'd2,  3'b000}
  };

  logic [7:0]  bts [128];
  logic [31:0] dws [32];

  tdg_gather u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ring_base(ring_base), .ring_idx(ring_idx),
    .busy(busy), .desc_addr(desc_addr), .dw_valid(dw_valid), .dw_ready(dw_ready),
    .dw_data(dw_data), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .done(done), .err_count(err_count), .err_len(err_len),
    .err_size(err_size)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] mk_len(input vec_t vv, input int i);
    if (i == int'(vv.bad_pos)) return vv.bad_len;
    return 12'(int'(vv.len_base) + i * int'(vv.step));
  endfunction

  function automatic logic [35:0] mk_addr(input int vn, input int i);
    return {4'(i + vn), 32'hA500_0000 + 32'(i) * 32'h0001_0111 + 32'(vn) * 32'h100};
  endfunction

  task automatic build(input vec_t vv, input int vn);
    for (int b = 0; b < 128; b++) bts[b] = 8'h5A;
    bts[0] = 8'hEE; bts[1] = 8'hEE; bts[2] = 8'hEE;
    bts[3] = {3'b111, vv.cnt};            // R3: junk in bits 7:5
    for (int i = 0; i < 20; i++) begin
      logic [35:0] a;
      logic [15:0] h;
      a = mk_addr(vn, i);
      h = {mk_len(vv, i), a[35:32]};
      for (int j = 0; j < 4; j++) bts[4 + 6*i + j] = a[8*j +: 8];
      bts[8 + 6*i] = h[7:0];
      bts[9 + 6*i] = h[15:8];
    end
    for (int k = 0; k < 32; k++)
      dws[k] = {bts[4*k+3], bts[4*k+2], bts[4*k+1], bts[4*k]};
  endtask

  task automatic run_vec(input vec_t vv, input int vn, input bit poke);
    int k, n, last_acc, dcyc;
    bit acc;
    logic [35:0] exp_da;
    build(vv, vn);
    exp_da = {vv.base, 8'h00} + 36'(vv.idx) * 36'd128;
    @(negedge clk);
    ring_base = vv.base; ring_idx = vv.idx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    check(busy === 1'b1, "R1", "busy after start", 64'(busy), 64'd1);
    check(desc_addr === exp_da, "R1", "descriptor address", 64'(desc_addr), 64'(exp_da));
    k = 0;
    while (k < 32) begin
      if (k > 0 || acc) @(negedge clk);
      dw_valid = 1'b1; dw_data = dws[k];
      start    = (poke && k == 3);
      ring_idx = (poke && k == 3) ? ~vv.idx : vv.idx;
      #1 acc = dw_ready;
      @(posedge clk);
      if (acc) k++;
      acc = 1'b1;
    end
    @(negedge clk);
    dw_valid = 1'b0; start = 1'b0; ring_idx = vv.idx;
    #1;
    check(desc_addr === exp_da, "R10", "address after restart attempt", 64'(desc_addr), 64'(exp_da));
    check(dw_ready === 1'b0, "R2", "ready after 32 dwords", 64'(dw_ready), 64'd0);
    n = 0; last_acc = -10; dcyc = -1;
    for (int c = 0; c < 400; c++) begin
      if (c > 0) @(negedge clk);
      req_ready = vv.stall ? (c % 3 != 0) : 1'b1;
      #1;
      if (req_valid && req_ready) begin
        if (n < int'(vv.nreq)) begin
          check(req_addr === mk_addr(vn, n), "R5", "request address",
                64'(req_addr), 64'(mk_addr(vn, n)));
          check(req_len === mk_len(vv, n), "R6", "request length",
                64'(req_len), 64'(mk_len(vv, n)));
        end else begin
          check(1'b0, "R7", "extra request", 64'(n), 64'(vv.nreq));
        end
        n++;
        last_acc = c;
      end
      if (done) begin
        dcyc = c;
        break;
      end
    end
    req_ready = 1'b0;
    check(n == int'(vv.nreq), "R8", "request count", 64'(n), 64'(vv.nreq));
    check(dcyc >= 0, "R9", "done seen", 64'(dcyc >= 0), 64'd1);
    if (vv.nreq != 0)
      check(dcyc == last_acc + 1, "R9", "done timing", 64'(dcyc), 64'(last_acc + 1));
    check({err_size, err_len, err_count} === vv.errs, "R4", "error flags",
          64'({err_size, err_len, err_count}), 64'(vv.errs));
    @(negedge clk);
    #1;
    check(done === 1'b0 && busy === 1'b0, "R9", "done single cycle",
          64'({done, busy}), 64'd0);
    check({err_size, err_len, err_count} === vv.errs, "R9", "flags held",
          64'({err_size, err_len, err_count}), 64'(vv.errs));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R9 watchdog: done=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; ring_base = '0; ring_idx = '0;
    dw_valid = 1'b0; dw_data = '0; req_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check({busy, dw_ready, req_valid, done} === 4'b0, "R2", "reset outputs",
          64'({busy, dw_ready, req_valid, done}), 64'd0);
    check({err_size, err_len, err_count} === 3'b0, "R9", "reset flags",
          64'({err_size, err_len, err_count}), 64'd0);
    // Table walk: R3 R4 R5 R6 R7 R8 covered by the vectors above.
    for (int v = 0; v < NV; v++) run_vec(VECS[v], v, 1'b0);
    // Directed: start during load is ignored (R10), flags cleared by new start (R9).
    run_vec(VECS[1], 11, 1'b1);
    run_vec(VECS[0], 12, 1'b1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule